// File: doc/BRIEF.md
# Fixed-Point Add Family Execution Unit

This unit executes one group of 64-bit fixed-point add instructions. Each issue supplies a 32-bit instruction word, two source operands, a width mode (full 64-bit or narrow 32-bit) and the current exception flags: carry, half carry, overflow, half overflow and sticky summary overflow. The unit decodes the instruction and forms the sum. It returns the result, the new flag values with a write enable for each flag group, an optional condition-field update for record forms, and an illegal-instruction indication.

The group covers the plain add, the carrying add, the extended add, and the adds of minus one and of zero. Each comes with an overflow-checking variant and a record variant. The group also includes an extended add that takes its carry from the overflow pair of flags instead of the carry pair and returns its carry there. Operand fetch and result write-back belong to the surrounding pipeline. By default the outputs are registered and due one cycle after issue. A parameter selects a purely combinational variant instead.

Top module: `fxadd_exec`

## Requirements
- R1: The unit takes the instruction as part of the group only when insn[31:26] = 31 and insn[5:1] = 0x0A. The sub-opcode is insn[10:6] and the record bit is insn[0]. Any other primary or secondary value, and any sub-opcode outside the list below, sets illegal_o and clears every write enable (res_we_o, ca_we_o, ov_we_o, so_we_o, cr0_we_o). When no flag is written, each flag output equals its input.
- R2: Sub-opcodes 0x08 and 0x18 return A+B. They ignore ca_i and leave ca_we_o at 0.
- R3: Sub-opcodes 0x00 and 0x10 return A+B without a carry-in and write the carry pair (ca_we_o = 1).
- R4: Sub-opcodes 0x04 and 0x14 return A+B+ca_i and write the carry pair.
- R5: Sub-opcodes 0x07 and 0x06 return A+all-ones+ca_i and A+0+ca_i respectively. Both ignore src_b_i and both write the carry pair.
- R6: The half-carry output equals bit 32 of (A xor B' xor result), where B' is the effective second operand. In 64-bit mode the carry output is the carry out of bit 63. In 32-bit mode (narrow_i = 1) the carry output equals the half carry.
- R7: Sub-opcode 0x05 with insn[0] = 0 returns A+B+ov_i. It writes the carry to ov_o and the half carry to ov32_o (ov_we_o = 1). It leaves ca_o/ca32_o equal to their inputs with ca_we_o = 0, and so_we_o = 0 and cr0_we_o = 0.
- R8: Encodings with a nonzero carry-select field, meaning sub-opcodes 0x0D, 0x15 and 0x1D, are illegal. Sub-opcode 0x05 with insn[0] = 1 is also illegal.
- R9: The overflow variants (sub-opcode bit 4 set, i.e. insn[10] = 1) write ov_o with the signed overflow of the 64-bit sum (of the low 32 bits in 32-bit mode) and ov32_o with the signed overflow of the low 32 bits. They set so_o = so_i | ov_o, with ov_we_o = so_we_o = 1.
- R10: Record forms (insn[0] = 1) set cr0_we_o = 1 and cr0_o = {lt, gt, eq, so_o}. These come from a signed comparison of the result with zero, using the low 32 bits in 32-bit mode.
- R11: With the default registered variant, results and done_o appear one cycle after an issue_i pulse. done_o and all write enables are 0 in every other cycle and while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | Instruction presented this cycle |
| insn_i | input | 32 | Instruction word |
| src_a_i | input | XLEN | First source operand |
| src_b_i | input | XLEN | Second source operand |
| narrow_i | input | 1 | 1 = 32-bit mode |
| ca_i | input | 1 | Current carry |
| ca32_i | input | 1 | Current half carry |
| ov_i | input | 1 | Current overflow |
| ov32_i | input | 1 | Current half overflow |
| so_i | input | 1 | Current summary overflow |
| done_o | output | 1 | Results valid |
| result_o | output | XLEN | Sum |
| res_we_o | output | 1 | Result write enable |
| ca_o | output | 1 | New carry |
| ca32_o | output | 1 | New half carry |
| ca_we_o | output | 1 | Carry pair write enable |
| ov_o | output | 1 | New overflow |
| ov32_o | output | 1 | New half overflow |
| ov_we_o | output | 1 | Overflow pair write enable |
| so_o | output | 1 | New summary overflow |
| so_we_o | output | 1 | Summary overflow write enable |
| cr0_o | output | 4 | Condition field {lt, gt, eq, so} |
| cr0_we_o | output | 1 | Condition field write enable |
| illegal_o | output | 1 | Illegal instruction |

## Verification
Every output of the registered variant is due exactly one clock edge after the edge that samples issue_i. The bench drives each issue on a falling edge and samples all outputs on the next falling edge, half a period after the capturing edge. One falling edge later it checks that done_o and the write enables have returned to 0. The checker's properties compare the outputs with the inputs from the previous cycle through $past, which gives the same one-cycle offset.

// File: rtl/fxadd_pkg.sv
package fxadd_pkg;

   localparam int unsigned INSN_W       = 32;
   localparam logic [5:0]  PRIMARY_OP   = 6'd31;
   localparam logic [4:0]  SECONDARY_OP = 5'h0A;
   localparam logic [4:0]  SUB_ALT      = 5'h05;

   typedef enum logic [1:0] {
      BSEL_REG  = 2'd0,
      BSEL_ONES = 2'd1,
      BSEL_ZERO = 2'd2
   } bsel_e;

   typedef enum logic [1:0] {
      CIN_NONE = 2'd0,
      CIN_CA   = 2'd1,
      CIN_OV   = 2'd2
   } cin_e;

   typedef struct packed {
      logic  legal;
      bsel_e bsel;
      cin_e  cin;
      logic  wr_ca;
      logic  wr_ov_carry;
      logic  chk_ov;
      logic  rec;
   } dec_t;

endpackage

// File: rtl/fxadd_decode.sv
module fxadd_decode
   import fxadd_pkg::*;
(
   input  logic [INSN_W-1:0] insn,
   output dec_t              dec
);

   logic [5:0] primary;
   logic [4:0] secondary;
   logic [4:0] sub;
   logic       rc;
   logic       unused_fields;

   assign primary       = insn[31:26];
   assign secondary     = insn[5:1];
   assign sub           = insn[10:6];
   assign rc            = insn[0];
   assign unused_fields = ^insn[25:11];

   always_comb begin
      dec      = '0;
      dec.bsel = BSEL_REG;
      dec.cin  = CIN_NONE;
      if (primary == PRIMARY_OP && secondary == SECONDARY_OP) begin
         if (sub == SUB_ALT) begin
            if (!rc) begin
               dec.legal       = 1'b1;
               dec.cin         = CIN_OV;
               dec.wr_ov_carry = 1'b1;
            end
         end else begin
            case (sub[3:0])
               4'h8: dec.legal = 1'b1;
               4'h0: begin
                  dec.legal = 1'b1;
                  dec.wr_ca = 1'b1;
               end
               4'h4: begin
                  dec.legal = 1'b1;
                  dec.cin   = CIN_CA;
                  dec.wr_ca = 1'b1;
               end
               4'h7: begin
                  dec.legal = 1'b1;
                  dec.bsel  = BSEL_ONES;
                  dec.cin   = CIN_CA;
                  dec.wr_ca = 1'b1;
               end
               4'h6: begin
                  dec.legal = 1'b1;
                  dec.bsel  = BSEL_ZERO;
                  dec.cin   = CIN_CA;
                  dec.wr_ca = 1'b1;
               end
               default: dec.legal = 1'b0;
            endcase
            dec.chk_ov = dec.legal & sub[4];
            dec.rec    = dec.legal & rc;
         end
      end
   end

endmodule

// File: rtl/fxadd_core.sv
module fxadd_core
   import fxadd_pkg::*;
#(
   parameter int unsigned XLEN = 64,
   parameter int unsigned HALF = XLEN / 2
) (
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   input  logic            narrow,
   input  dec_t            dec,
   input  logic            ca_i,
   input  logic            ca32_i,
   input  logic            ov_i,
   input  logic            ov32_i,
   input  logic            so_i,
   output logic [XLEN-1:0] res,
   output logic            ca_o,
   output logic            ca32_o,
   output logic            ov_o,
   output logic            ov32_o,
   output logic            so_o,
   output logic [3:0]      cr0,
   output logic [4:0]      we,
   output logic            illegal
);

   localparam int unsigned SUM_W = XLEN + 1;

   logic [XLEN-1:0]  opb;
   logic             cin;
   logic [SUM_W-1:0] wide;
   logic             c_half, c_out, v_full, v_half, ov_new;
   logic             ca_we, ov_we, so_we, cr0_we;
   logic             sgn, zero;

   always_comb begin
      case (dec.bsel)
         BSEL_ONES: opb = '1;
         BSEL_ZERO: opb = '0;
         default:   opb = b;
      endcase
      case (dec.cin)
         CIN_CA:  cin = ca_i;
         CIN_OV:  cin = ov_i;
         default: cin = 1'b0;
      endcase
   end

   assign wide   = {1'b0, a} + {1'b0, opb} + {{XLEN{1'b0}}, cin};
   assign res    = wide[XLEN-1:0];
   assign c_half = a[HALF] ^ opb[HALF] ^ res[HALF];
   assign c_out  = narrow ? c_half : wide[XLEN];
   assign v_full = (a[XLEN-1] == opb[XLEN-1]) && (res[XLEN-1] != a[XLEN-1]);
   assign v_half = (a[HALF-1] == opb[HALF-1]) && (res[HALF-1] != a[HALF-1]);

   assign ca_we  = dec.legal & dec.wr_ca;
   assign ov_we  = dec.legal & (dec.wr_ov_carry | dec.chk_ov);
   assign so_we  = dec.legal & dec.chk_ov;
   assign cr0_we = dec.legal & dec.rec;

   assign ov_new = dec.wr_ov_carry ? c_out : (narrow ? v_half : v_full);

   assign ca_o   = ca_we ? c_out  : ca_i;
   assign ca32_o = ca_we ? c_half : ca32_i;
   assign ov_o   = ov_we ? ov_new : ov_i;
   assign ov32_o = ov_we ? (dec.wr_ov_carry ? c_half : v_half) : ov32_i;
   assign so_o   = so_we ? (so_i | ov_new) : so_i;

   assign sgn  = narrow ? res[HALF-1] : res[XLEN-1];
   assign zero = narrow ? (res[HALF-1:0] == '0) : (res == '0);
   assign cr0  = {sgn, ~sgn & ~zero, zero, so_o};

   assign we      = {dec.legal, ca_we, ov_we, so_we, cr0_we};
   assign illegal = ~dec.legal;

endmodule

// File: rtl/fxadd_exec.sv
module fxadd_exec
   import fxadd_pkg::*;
#(
   parameter int unsigned XLEN       = 64,
   parameter int unsigned HALF       = XLEN / 2,
   parameter bit          REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue_i,
   input  logic [INSN_W-1:0] insn_i,
   input  logic [XLEN-1:0]   src_a_i,
   input  logic [XLEN-1:0]   src_b_i,
   input  logic              narrow_i,
   input  logic              ca_i,
   input  logic              ca32_i,
   input  logic              ov_i,
   input  logic              ov32_i,
   input  logic              so_i,
   output logic              done_o,
   output logic [XLEN-1:0]   result_o,
   output logic              res_we_o,
   output logic              ca_o,
   output logic              ca32_o,
   output logic              ca_we_o,
   output logic              ov_o,
   output logic              ov32_o,
   output logic              ov_we_o,
   output logic              so_o,
   output logic              so_we_o,
   output logic [3:0]        cr0_o,
   output logic              cr0_we_o,
   output logic              illegal_o
);

   localparam int unsigned FLAG_N = 5;
   localparam int unsigned WE_N   = 5;
   localparam int unsigned CR_W   = 4;
   localparam int unsigned WE_LSB = 1;
   localparam int unsigned BUN_W  = XLEN + FLAG_N + CR_W + WE_N + 1;

   if (XLEN < 8 || (XLEN % 2) != 0) begin : g_bad_xlen
      $error("fxadd_exec: XLEN must be even and at least 8");
   end
   if (HALF < 2 || HALF >= XLEN) begin : g_bad_half
      $error("fxadd_exec: HALF must lie between 2 and XLEN-1");
   end

   dec_t              dec;
   logic [XLEN-1:0]   c_res;
   logic              c_ca, c_ca32, c_ov, c_ov32, c_so, c_ill;
   logic [CR_W-1:0]   c_cr0;
   logic [WE_N-1:0]   c_we;
   logic [BUN_W-1:0]  comb_bun;
   logic [BUN_W-1:0]  out_bun;
   logic              done_int;
   logic [WE_N-1:0]   out_we;
   logic              out_ill;

   fxadd_decode u_dec (
      .insn (insn_i),
      .dec  (dec)
   );

   fxadd_core #(.XLEN(XLEN), .HALF(HALF)) u_core (
      .a       (src_a_i),
      .b       (src_b_i),
      .narrow  (narrow_i),
      .dec     (dec),
      .ca_i    (ca_i),
      .ca32_i  (ca32_i),
      .ov_i    (ov_i),
      .ov32_i  (ov32_i),
      .so_i    (so_i),
      .res     (c_res),
      .ca_o    (c_ca),
      .ca32_o  (c_ca32),
      .ov_o    (c_ov),
      .ov32_o  (c_ov32),
      .so_o    (c_so),
      .cr0     (c_cr0),
      .we      (c_we),
      .illegal (c_ill)
   );

   assign comb_bun = {c_res, c_ca, c_ca32, c_ov, c_ov32, c_so, c_cr0, c_we, c_ill};

   if (REGISTERED) begin : g_reg
      logic [BUN_W-1:0] bun_q;
      logic             done_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            done_q <= 1'b0;
            bun_q  <= '0;
         end else begin
            done_q <= issue_i;
            if (issue_i) begin
               bun_q <= comb_bun;
            end else begin
               bun_q[WE_LSB +: WE_N] <= '0;
            end
         end
      end
      assign out_bun  = bun_q;
      assign done_int = done_q;
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign out_bun    = comb_bun;
      assign done_int   = issue_i;
   end

   assign out_we  = out_bun[WE_LSB +: WE_N] & {WE_N{done_int}};
   assign out_ill = out_bun[0] & done_int;

   assign done_o    = done_int;
   assign result_o  = out_bun[BUN_W-1 -: XLEN];
   assign ca_o      = out_bun[CR_W + WE_N + 5];
   assign ca32_o    = out_bun[CR_W + WE_N + 4];
   assign ov_o      = out_bun[CR_W + WE_N + 3];
   assign ov32_o    = out_bun[CR_W + WE_N + 2];
   assign so_o      = out_bun[CR_W + WE_N + 1];
   assign cr0_o     = out_bun[WE_N + 1 +: CR_W];
   assign res_we_o  = out_we[4];
   assign ca_we_o   = out_we[3];
   assign ov_we_o   = out_we[2];
   assign so_we_o   = out_we[1];
   assign cr0_we_o  = out_we[0];
   assign illegal_o = out_ill;

endmodule

// File: rtl/fxadd_exec_chk.sv
module fxadd_exec_chk #(
   parameter bit REGISTERED = 1'b1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       issue_i,
   input logic       narrow_i,
   input logic       ca_i,
   input logic       ca32_i,
   input logic       so_i,
   input logic       done_o,
   input logic       res_we_o,
   input logic       ca_o,
   input logic       ca32_o,
   input logic       ca_we_o,
   input logic       ov_we_o,
   input logic       so_o,
   input logic       so_we_o,
   input logic [3:0] cr0_o,
   input logic       cr0_we_o,
   input logic       illegal_o
);

   if (REGISTERED) begin : g_seq
      // R1
      illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
         done_o && illegal_o |-> !(res_we_o || ca_we_o || ov_we_o || so_we_o || cr0_we_o));

      // R7
      alt_keeps_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
         done_o && ov_we_o && !so_we_o |->
            !ca_we_o && !cr0_we_o && ca_o == $past(ca_i) && ca32_o == $past(ca32_i));

      // R6
      narrow_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
         done_o && ca_we_o && $past(narrow_i) |-> ca_o == ca32_o);

      // R9
      so_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
         done_o && $past(so_i) |-> so_o);

      // R10
      cr0_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
         done_o && cr0_we_o |-> cr0_o[0] == so_o && $countones(cr0_o[3:1]) == 1);

      // R11
      done_follows_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) |-> done_o == $past(issue_i));

      // R11
      idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !done_o |-> !(res_we_o || ca_we_o || ov_we_o || so_we_o || cr0_we_o || illegal_o));
   end else begin : g_imm
      always_comb begin
         // R1
         if (illegal_o) begin
            illegal_quiet_chk: assert (!(res_we_o || ca_we_o || ov_we_o || so_we_o || cr0_we_o));
         end
      end
   end

endmodule

bind fxadd_exec fxadd_exec_chk #(.REGISTERED(REGISTERED)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .issue_i   (issue_i),
   .narrow_i  (narrow_i),
   .ca_i      (ca_i),
   .ca32_i    (ca32_i),
   .so_i      (so_i),
   .done_o    (done_o),
   .res_we_o  (res_we_o),
   .ca_o      (ca_o),
   .ca32_o    (ca32_o),
   .ca_we_o   (ca_we_o),
   .ov_we_o   (ov_we_o),
   .so_o      (so_o),
   .so_we_o   (so_we_o),
   .cr0_o     (cr0_o),
   .cr0_we_o  (cr0_we_o),
   .illegal_o (illegal_o)
);

// File: tb/fxadd_exec_test.sv
module fxadd_exec_test;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        issue_i = 1'b0;
   logic [31:0] insn_i = '0;
   logic [63:0] src_a_i = '0, src_b_i = '0;
   logic        narrow_i = 1'b0;
   logic        ca_i = 1'b0, ca32_i = 1'b0, ov_i = 1'b0, ov32_i = 1'b0, so_i = 1'b0;
   logic        done_o, res_we_o, ca_o, ca32_o, ca_we_o, ov_o, ov32_o, ov_we_o;
   logic        so_o, so_we_o, cr0_we_o, illegal_o;
   logic [63:0] result_o;
   logic [3:0]  cr0_o;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fxadd_exec uut (
      .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .insn_i(insn_i),
      .src_a_i(src_a_i), .src_b_i(src_b_i), .narrow_i(narrow_i),
      .ca_i(ca_i), .ca32_i(ca32_i), .ov_i(ov_i), .ov32_i(ov32_i), .so_i(so_i),
      .done_o(done_o), .result_o(result_o), .res_we_o(res_we_o),
      .ca_o(ca_o), .ca32_o(ca32_o), .ca_we_o(ca_we_o),
      .ov_o(ov_o), .ov32_o(ov32_o), .ov_we_o(ov_we_o),
      .so_o(so_o), .so_we_o(so_we_o), .cr0_o(cr0_o), .cr0_we_o(cr0_we_o),
      .illegal_o(illegal_o)
   );

   function automatic logic [31:0] mk(input logic [5:0] prim, input logic [4:0] sub,
                                      input logic [4:0] sec, input logic rc);
      return {prim, 5'd3, 5'd4, 5'd5, sub, sec, rc};
   endfunction

   function automatic logic [31:0] op(input logic [4:0] sub, input logic rc);
      return mk(6'd31, sub, 5'h0A, rc);
   endfunction

   task automatic check(input string tag, input string what, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // Issue one instruction, compute the expected outcome from the requirements,
   // and compare at the falling edge after the capturing edge (one cycle latency).
   task automatic run(input string tag, input logic [31:0] insn, input logic [63:0] a,
                      input logic [63:0] b, input logic nar, input logic [4:0] fl);
      logic [4:0]  sub;
      logic        rc, alt, legal, oe, wcar, rdcar;
      logic [63:0] bb, e_res;
      logic        cin, c32, c64, v64, v32, vsel;
      logic [64:0] s65, sv;
      logic [32:0] lo, lv;
      logic        e_ca, e_ca32, e_ov, e_ov32, e_so, e_caw, e_ovw, e_sow, e_crw;
      logic        sg, zr;
      sub   = insn[10:6];
      rc    = insn[0];
      alt   = (sub == 5'h05);
      oe    = sub[4];
      legal = (insn[31:26] == 6'd31) && (insn[5:1] == 5'h0A) &&
              ((alt && !rc) || (!alt && (sub[3:0] inside {4'h8, 4'h0, 4'h4, 4'h7, 4'h6})));
      bb    = (!alt && sub[3:0] == 4'h7) ? 64'hFFFF_FFFF_FFFF_FFFF :
              (!alt && sub[3:0] == 4'h6) ? 64'd0 : b;
      rdcar = !alt && (sub[3:0] inside {4'h4, 4'h7, 4'h6});
      wcar  = !alt && (sub[3:0] inside {4'h0, 4'h4, 4'h7, 4'h6});
      cin   = alt ? fl[2] : (rdcar ? fl[4] : 1'b0);
      s65   = {1'b0, a} + {1'b0, bb} + 65'(cin);
      lo    = {1'b0, a[31:0]} + {1'b0, bb[31:0]} + 33'(cin);
      e_res = s65[63:0];
      c32   = lo[32];
      c64   = nar ? c32 : s65[64];
      sv    = {a[63], a} + {bb[63], bb} + 65'(cin);
      lv    = {a[31], a[31:0]} + {bb[31], bb[31:0]} + 33'(cin);
      v64   = sv[64] ^ sv[63];
      v32   = lv[32] ^ lv[31];
      vsel  = nar ? v32 : v64;
      e_caw = legal && wcar;
      e_ovw = legal && (alt || oe);
      e_sow = legal && !alt && oe;
      e_crw = legal && !alt && rc;
      e_ca   = e_caw ? c64 : fl[4];
      e_ca32 = e_caw ? c32 : fl[3];
      e_ov   = e_ovw ? (alt ? c64 : vsel) : fl[2];
      e_ov32 = e_ovw ? (alt ? c32 : v32) : fl[1];
      e_so   = e_sow ? (fl[0] | vsel) : fl[0];
      sg = nar ? e_res[31] : e_res[63];
      zr = nar ? (e_res[31:0] == 0) : (e_res == 0);

      @(negedge clk);
      issue_i = 1'b1; insn_i = insn; src_a_i = a; src_b_i = b; narrow_i = nar;
      {ca_i, ca32_i, ov_i, ov32_i, so_i} = fl;
      @(negedge clk);
      issue_i = 1'b0;
      check(tag, "done", 64'(done_o), 64'd1);
      check(tag, "illegal", 64'(illegal_o), 64'(!legal));
      check(tag, "we{res,ca,ov,so,cr0}",
            64'({res_we_o, ca_we_o, ov_we_o, so_we_o, cr0_we_o}),
            64'({legal, e_caw, e_ovw, e_sow, e_crw}));
      check(tag, "flags{ca,ca32,ov,ov32,so}",
            64'({ca_o, ca32_o, ov_o, ov32_o, so_o}),
            64'({e_ca, e_ca32, e_ov, e_ov32, e_so}));
      if (legal) check(tag, "result", result_o, e_res);
      if (e_crw) check(tag, "cr0", 64'(cr0_o), 64'({sg, !sg && !zr, zr, e_so}));
   endtask

   task automatic t_reset();
      check("R11", "done in reset", 64'(done_o), 64'd0);
      check("R11", "we in reset",
            64'({res_we_o, ca_we_o, ov_we_o, so_we_o, cr0_we_o}), 64'd0);
   endtask

   task automatic t_plain_add();
      run("R2", op(5'h08, 1'b0), 64'h0123_4567_89AB_CDEF, 64'h1111_1111_1111_1111, 1'b0, 5'b11000);
      run("R2", op(5'h08, 1'b0), 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1'b0, 5'b10000);
   endtask

   task automatic t_carrying();
      run("R3", op(5'h00, 1'b0), 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 1'b0, 5'b10000);
      run("R3", op(5'h00, 1'b0), 64'd5, 64'd7, 1'b0, 5'b11000);
   endtask

   task automatic t_extended();
      run("R4", op(5'h04, 1'b0), 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 1'b0, 5'b10000);
      run("R4", op(5'h04, 1'b0), 64'd10, 64'd20, 1'b0, 5'b00000);
   endtask

   task automatic t_minus_zero();
      run("R5", op(5'h07, 1'b0), 64'd0, 64'hDEAD_BEEF, 1'b0, 5'b00000);
      run("R5", op(5'h07, 1'b0), 64'd9, 64'h1234, 1'b0, 5'b10000);
      run("R5", op(5'h06, 1'b0), 64'hFFFF_FFFF_FFFF_FFFF, 64'h5555, 1'b0, 5'b10000);
      run("R5", op(5'h06, 1'b0), 64'd42, 64'hAAAA, 1'b0, 5'b00000);
   endtask

   task automatic t_half_carry();
      run("R6", op(5'h00, 1'b0), 64'h0000_0000_FFFF_FFFF, 64'd1, 1'b0, 5'b00000);
      run("R6", op(5'h00, 1'b0), 64'h0000_0000_FFFF_FFFF, 64'd1, 1'b1, 5'b00000);
      run("R6", op(5'h04, 1'b0), 64'hFFFF_FFFF_0000_0000, 64'hFFFF_FFFF_0000_0000, 1'b1, 5'b10000);
   endtask

   task automatic t_alt();
      run("R7", op(5'h05, 1'b0), 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 1'b0, 5'b00100);
      run("R7", op(5'h05, 1'b0), 64'd100, 64'd23, 1'b0, 5'b11001);
      run("R7", op(5'h05, 1'b0), 64'h0000_0000_FFFF_FFFF, 64'd0, 1'b1, 5'b00110);
   endtask

   task automatic t_alt_bad();
      run("R8", op(5'h0D, 1'b0), 64'd1, 64'd2, 1'b0, 5'b10101);
      run("R8", op(5'h15, 1'b0), 64'd1, 64'd2, 1'b0, 5'b01010);
      run("R8", op(5'h1D, 1'b0), 64'd1, 64'd2, 1'b0, 5'b00000);
      run("R8", op(5'h05, 1'b1), 64'd1, 64'd2, 1'b0, 5'b00100);
   endtask

   task automatic t_overflow();
      run("R9", op(5'h18, 1'b0), 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 1'b0, 5'b00000);
      run("R9", op(5'h18, 1'b0), 64'd3, 64'd4, 1'b0, 5'b00111);
      run("R9", op(5'h18, 1'b0), 64'h0000_0000_7FFF_FFFF, 64'd1, 1'b1, 5'b00000);
      run("R9", op(5'h14, 1'b0), 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0, 5'b10000);
      run("R9", op(5'h17, 1'b0), 64'h8000_0000_0000_0000, 64'd5, 1'b0, 5'b00000);
      run("R9", op(5'h16, 1'b0), 64'h7FFF_FFFF_FFFF_FFFF, 64'd0, 1'b0, 5'b10000);
   endtask

   task automatic t_record();
      run("R10", op(5'h08, 1'b1), 64'hFFFF_FFFF_FFFF_FFF0, 64'd1, 1'b0, 5'b00001);
      run("R10", op(5'h08, 1'b1), 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1'b0, 5'b00000);
      run("R10", op(5'h00, 1'b1), 64'd3, 64'd4, 1'b0, 5'b00000);
      run("R10", op(5'h08, 1'b1), 64'h0000_0001_8000_0000, 64'd0, 1'b1, 5'b00000);
      run("R10", op(5'h18, 1'b1), 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 1'b0, 5'b00000);
   endtask

   task automatic t_illegal();
      run("R1", mk(6'd30, 5'h08, 5'h0A, 1'b0), 64'd1, 64'd1, 1'b0, 5'b10101);
      run("R1", mk(6'd31, 5'h08, 5'h0B, 1'b0), 64'd1, 64'd1, 1'b0, 5'b01010);
      run("R1", op(5'h01, 1'b0), 64'd1, 64'd1, 1'b0, 5'b11111);
      run("R1", op(5'h1F, 1'b1), 64'd1, 64'd1, 1'b0, 5'b00000);
   endtask

   task automatic t_timing();
      run("R11", op(5'h08, 1'b0), 64'd1, 64'd2, 1'b0, 5'b00000);
      @(negedge clk);
      check("R11", "done after idle", 64'(done_o), 64'd0);
      check("R11", "we after idle",
            64'({res_we_o, ca_we_o, ov_we_o, so_we_o, cr0_we_o}), 64'd0);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL R11 watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_plain_add();
      t_carrying();
      t_extended();
      t_minus_zero();
      t_half_carry();
      t_alt();
      t_alt_bad();
      t_overflow();
      t_record();
      t_illegal();
      t_timing();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule